// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs an external 12-bit parallel-output sampling converter from a synchronous system clock. It raises the converter's start line for a fixed, clock-derived high time. It then follows the converter's busy (end-of-conversion) line through its high phase and back to low. After a settling delay it enables the converter's outputs and registers the 12-bit word. Each captured sample comes out with a one-cycle valid strobe. It is returned either as raw offset binary or as two's complement.

Conversions start in one of two ways. In single-shot mode each request pulse starts one conversion. In free-running mode a programmable divider starts one every `rate_div_i` cycles. A trigger is only accepted while the sequencer is idle and the synchronised busy line is low. A start during a conversion would corrupt the result, so any trigger refused for that reason is counted as dropped. A watchdog counter ends a conversion whose busy line never completes its high-then-low cycle. It then reports a timeout.

Top module: `adc_seq`

## Requirements
- R1: While `rst_ni` is low, `adc_start_o`=0, `adc_oe_no`=1, `smp_valid_o`=0, `timeout_o`=0, `busy_o`=0 and `drop_cnt_o`=0.
- R2: Each start pulse stays high for exactly ceil(START_NS*1000/CLK_PS) cycles. That is 25 cycles with the defaults (100 ns at a 4 ns clock).
- R3: No start pulse is issued while the synchronised busy line is high. A trigger refused for that reason adds one to `drop_cnt_o`.
- R4: The word is registered once the busy line has been low for at least SETTLE cycles. SETTLE is ceil(max(20 ns, 10 ns)/clock), which is 5 cycles with the defaults. `smp_valid_o` rises between 5 and 8 cycles after the busy line is first seen low. It carries the word the converter presented at that moment.
- R5: `adc_oe_no` is low only during the settle window ahead of a capture. It is never low while `adc_start_o` is high.
- R6: With `fmt_i`=0 the output is the raw offset-binary word. With `fmt_i`=1 bit 11 is inverted: 0x800 becomes 0x000, 0x000 becomes 0x800, 0xFFF becomes 0x7FF and 0x400 becomes 0xC00. `fmt_i` is sampled in the capture cycle.
- R7: In single-shot mode (`mode_i`=0) one `req_i` pulse accepted while idle produces exactly one sample.
- R8: In free-running mode (`mode_i`=1) start pulses rise exactly `rate_div_i` cycles apart when the converter keeps up. A `rate_div_i` of 0 acts as 1.
- R9: A trigger that arrives while a conversion is in progress adds one to `drop_cnt_o`. The counter saturates at its all-ones value.
- R10: If the busy line has not gone high and back low within TIMEOUT cycles of the start (100 with the defaults), `timeout_o` pulses for one cycle. No sample is produced and the sequencer returns to idle.
- R11: `smp_valid_o` is high for exactly one cycle per capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 single-shot, 1 free-running |
| fmt_i | input | 1 | 0 offset binary, 1 two's complement |
| req_i | input | 1 | Single-shot conversion request |
| rate_div_i | input | DIV_W | Free-running period in cycles |
| adc_eoc_i | input | 1 | Converter busy line, asynchronous |
| adc_data_i | input | DATA_W | Converter parallel data |
| adc_start_o | output | 1 | Start-convert pulse |
| adc_oe_no | output | 1 | Converter output enable, active low |
| smp_valid_o | output | 1 | Sample strobe |
| smp_data_o | output | DATA_W | Sample word |
| busy_o | output | 1 | Conversion in progress |
| timeout_o | output | 1 | Busy line failed to complete |
| drop_cnt_o | output | DROP_W | Saturating count of refused triggers |

## Verification
A sequencer stuck outside idle stops `adc_start_o` from rising. Within one free-running period the start spacing or the sample count is wrong, and a missing busy edge shows as `timeout_o` after 100 cycles. A settle count that is off shows at once as a capture latency outside the 5 to 8 cycle window. It also shows as the model's garbage value 0xA5A or 0x3C3 in place of the expected word. A wrong start-width or drop counter shows on the first conversion, as a pulse length other than 25 or a drop count one too high or too low.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_WAIT_HI, ST_WAIT_LO, ST_SETTLE
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/adc_seq_rate.sv
`timescale 1ns/1ps
module adc_seq_rate #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // zero divider behaves as one
  assign lim = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned START_CYC  = 25,
  parameter int unsigned SETTLE_CYC = 5,
  parameter int unsigned TMO_CYC    = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic eoc_i,
  output logic accept_o,
  output logic start_o,
  output logic oe_no,
  output logic cap_o,
  output logic tmo_o,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(max2(START_CYC, SETTLE_CYC) + 1);
  localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] START_LAST  = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [TMO_W-1:0] TMO_LAST    = TMO_W'(TMO_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_cnt_q;
  logic             seen_q;
  logic             waiting;

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = trig_i && idle_o && !eoc_i;
  assign cap_o    = (state_q == ST_SETTLE) && (cnt_q == SETTLE_LAST);
  assign waiting  = (state_q == ST_START) || (state_q == ST_WAIT_HI) ||
                    (state_q == ST_WAIT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tmo_cnt_q <= '0;
      seen_q    <= 1'b0;
      start_o   <= 1'b0;
      oe_no     <= 1'b1;
      tmo_o     <= 1'b0;
    end else begin
      tmo_o <= 1'b0;
      if (waiting) tmo_cnt_q <= tmo_cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q   <= ST_START;
          start_o   <= 1'b1;
          cnt_q     <= '0;
          tmo_cnt_q <= '0;
          seen_q    <= 1'b0;
        end
        ST_START: begin
          cnt_q <= cnt_q + 1'b1;
          if (eoc_i) seen_q <= 1'b1;
          if (cnt_q == START_LAST) begin
            start_o <= 1'b0;
            state_q <= ST_WAIT_HI;
          end
        end
        ST_WAIT_HI: if (eoc_i || seen_q) state_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (!eoc_i) begin
          state_q <= ST_SETTLE;
          oe_no   <= 1'b0;
          cnt_q   <= '0;
        end
        ST_SETTLE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cap_o) begin
            oe_no   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // watchdog overrides any pending transition
      if (waiting && tmo_cnt_q == TMO_LAST) begin
        tmo_o   <= 1'b1;
        start_o <= 1'b0;
        oe_no   <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/adc_seq_fmt.sv
`timescale 1ns/1ps
module adc_seq_fmt #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              fmt_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= {raw_i[DATA_W-1] ^ fmt_i, raw_i[DATA_W-2:0]};
    end
  end
endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_PS        = 4000,
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned DIV_W         = 16,
  parameter int unsigned DROP_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned START_NS      = 100,
  parameter int unsigned EOC_SETTLE_NS = 20,
  parameter int unsigned OE_SETTLE_NS  = 10,
  parameter int unsigned TIMEOUT_NS    = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              fmt_i,
  input  logic              req_i,
  input  logic [DIV_W-1:0]  rate_div_i,
  input  logic              adc_eoc_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_start_o,
  output logic              adc_oe_no,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              busy_o,
  output logic              timeout_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int unsigned START_CYC  = ns_to_cyc(START_NS, CLK_PS);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(max2(EOC_SETTLE_NS, OE_SETTLE_NS), CLK_PS);
  localparam int unsigned TMO_CYC    = ns_to_cyc(TIMEOUT_NS, CLK_PS);

  logic eoc_s, tick, trig, accept, cap, idle;
  logic [DROP_W-1:0] drop_q;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(adc_eoc_i), .q_o(eoc_s)
  );

  adc_seq_rate #(.DIV_W(DIV_W)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode_i), .div_i(rate_div_i), .tick_o(tick)
  );

  assign trig = mode_i ? tick : req_i;

  adc_seq_ctrl #(
    .START_CYC(START_CYC), .SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .eoc_i(eoc_s),
    .accept_o(accept), .start_o(adc_start_o), .oe_no(adc_oe_no),
    .cap_o(cap), .tmo_o(timeout_o), .idle_o(idle)
  );

  adc_seq_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .fmt_i(fmt_i),
    .raw_i(adc_data_i), .valid_o(smp_valid_o), .data_o(smp_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          drop_q <= '0;
    else if (trig && !accept && ~&drop_q) drop_q <= drop_q + 1'b1;
  end

  assign busy_o     = !idle;
  assign drop_cnt_o = drop_q;
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned DROP_W    = 8,
  parameter int unsigned START_CYC = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fmt_i,
  input logic              eoc_s,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              adc_start_o,
  input logic              adc_oe_no,
  input logic              smp_valid_o,
  input logic [DATA_W-1:0] smp_data_o,
  input logic              timeout_o,
  input logic [DROP_W-1:0] drop_cnt_o
);
  logic [31:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt_q <= '0;
    else if (adc_start_o) hi_cnt_q <= hi_cnt_q + 1;
    else                  hi_cnt_q <= '0;
  end

  p_start_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_start_o) |-> hi_cnt_q == START_CYC);

  p_no_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_start_o) |-> !$past(eoc_s));

  p_cap_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(!adc_oe_no));

  p_oe_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_oe_no |-> !adc_start_o);

  p_format_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> smp_data_o == {$past(adc_data_i[DATA_W-1]) ^ $past(fmt_i),
                                   $past(adc_data_i[DATA_W-2:0])});

  p_drop_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o == $past(drop_cnt_o)) ||
             (drop_cnt_o == $past(drop_cnt_o) + 1'b1));

  p_tmo_no_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !smp_valid_o && adc_oe_no);

  p_valid_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);
endmodule

bind adc_seq adc_seq_chk #(
  .DATA_W(DATA_W), .DROP_W(DROP_W), .START_CYC(START_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .eoc_s(eoc_s),
  .adc_data_i(adc_data_i), .adc_start_o(adc_start_o), .adc_oe_no(adc_oe_no),
  .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o), .timeout_o(timeout_o),
  .drop_cnt_o(drop_cnt_o)
);

// File: tb/adc_seq_tb_top.sv
`timescale 1ns/1ps
module adc_seq_tb_top;
  // {code[24:13], fmt[12], expected[11:0]}
  localparam logic [24:0] VEC [8] = '{
    {12'h800, 1'b0, 12'h800}, {12'h800, 1'b1, 12'h000},
    {12'h000, 1'b0, 12'h000}, {12'h000, 1'b1, 12'h800},
    {12'hFFF, 1'b0, 12'hFFF}, {12'hFFF, 1'b1, 12'h7FF},
    {12'h400, 1'b1, 12'hC00}, {12'hC00, 1'b1, 12'h400}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic mode = 1'b0, fmt = 1'b0, req = 1'b0;
  logic [15:0] rate = '0;
  logic eoc_mdl = 1'b0, eoc_frc = 1'b0;
  logic eoc;
  logic [11:0] conv_word = 12'h000, code = 12'h000;
  int mdl_mode = 0;
  logic start, oe_n, valid, busy, tmo;
  logic [11:0] data_o, adc_data;
  logic [7:0] drop;

  assign eoc = eoc_mdl | eoc_frc;
  assign adc_data = oe_n ? 12'h3C3 : conv_word;

  adc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fmt_i(fmt), .req_i(req),
    .rate_div_i(rate), .adc_eoc_i(eoc), .adc_data_i(adc_data),
    .adc_start_o(start), .adc_oe_no(oe_n), .smp_valid_o(valid),
    .smp_data_o(data_o), .busy_o(busy), .timeout_o(tmo), .drop_cnt_o(drop)
  );

  // converter model: busy rises 9 ns after start, falls 147 ns after, data 15 ns later
  always @(posedge start) begin
    if (mdl_mode == 0) begin
      #9  eoc_mdl = 1'b1; conv_word = 12'hA5A;
      #138 eoc_mdl = 1'b0;
      #15 conv_word = code;
    end
  end

  int cyc = 0, total = 0, fails = 0;
  int hi_len = 0, last_width = 0, rise_cnt = 0, last_rise = 0, prev_rise = 0;
  int fall_cyc = 0, lat = 0, vcnt = 0, vrun = 0, vrun_max = 0, tmo_cnt = 0, oe_viol = 0;
  logic start_d = 1'b0, eoc_d = 1'b0;
  logic [11:0] last_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (start && !start_d) begin prev_rise = last_rise; last_rise = cyc; rise_cnt++; end
    if (start) hi_len++;
    else if (start_d) begin last_width = hi_len; hi_len = 0; end
    if (!eoc && eoc_d) fall_cyc = cyc;
    if (valid) begin
      if (vrun == 0) begin vcnt++; lat = cyc - fall_cyc; last_data = data_o; end
      vrun++;
      if (vrun > vrun_max) vrun_max = vrun;
    end else vrun = 0;
    if (tmo) tmo_cnt++;
    if (rst_n && !oe_n && start) oe_viol++;
    start_d = start;
    eoc_d = eoc;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic wait_valid(input int v0, input int lim);
    for (int i = 0; i < lim && vcnt == v0; i++) @(posedge clk);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v0, d0, r0, t0;
    repeat (5) @(negedge clk);
    check(start == 1'b0, "R1 start", start, 0);
    check(oe_n == 1'b1, "R1 oe_n", oe_n, 1);
    check(valid == 1'b0 && tmo == 1'b0, "R1 valid/timeout", {valid, tmo}, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(drop == 8'd0, "R1 drop", drop, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      code = VEC[i][24:13];
      fmt  = VEC[i][12];
      v0 = vcnt;
      pulse_req();
      wait_valid(v0, 200);
      check(vcnt == v0 + 1, "R7 one sample per request", vcnt - v0, 1);
      check(last_data == VEC[i][11:0], "R6 coding/R4 captured word", last_data, VEC[i][11:0]);
      if (i == 0) begin
        check(last_width == 25, "R2 start high cycles", last_width, 25);
        check(lat >= 5 && lat <= 8, "R4 capture latency", lat, 6);
      end
      repeat (5) @(negedge clk);
    end
    check(oe_viol == 0, "R5 oe low with start", oe_viol, 0);

    // R9: request while busy is dropped
    code = 12'h123; fmt = 1'b0;
    d0 = drop; v0 = vcnt;
    pulse_req();
    repeat (10) @(negedge clk);
    pulse_req();
    wait_valid(v0, 200);
    repeat (60) @(negedge clk);
    check(drop == d0 + 1, "R9 busy request dropped", drop, d0 + 1);
    check(vcnt == v0 + 1, "R7 busy request no extra sample", vcnt - v0, 1);
    check(vrun_max == 1, "R11 valid width", vrun_max, 1);

    // R3: busy line already high
    @(negedge clk) eoc_frc = 1'b1;
    repeat (5) @(negedge clk);
    r0 = rise_cnt; d0 = drop;
    pulse_req();
    repeat (30) @(negedge clk);
    check(rise_cnt == r0, "R3 no start while busy high", rise_cnt - r0, 0);
    check(drop == d0 + 1, "R3 refused request counted", drop, d0 + 1);
    eoc_frc = 1'b0;
    repeat (5) @(negedge clk);

    // R10: converter never answers
    mdl_mode = 1;
    v0 = vcnt; t0 = tmo_cnt;
    pulse_req();
    repeat (130) @(negedge clk);
    check(tmo_cnt == t0 + 1, "R10 timeout pulse", tmo_cnt - t0, 1);
    check(vcnt == v0, "R10 no sample on timeout", vcnt - v0, 0);
    check(busy == 1'b0 && oe_n == 1'b1, "R10 back to idle", {busy, oe_n}, 1);
    mdl_mode = 0;

    // R8: free-running spacing
    rate = 16'd100;
    @(negedge clk) mode = 1'b1;
    r0 = rise_cnt;
    for (int i = 0; i < 1000 && rise_cnt < r0 + 3; i++) @(posedge clk);
    check(last_rise - prev_rise == 100, "R8 free-run spacing", last_rise - prev_rise, 100);
    check(rise_cnt >= r0 + 3, "R8 free-run starts", rise_cnt - r0, 3);
    @(negedge clk) mode = 1'b0;
    repeat (80) @(negedge clk);

    // R8 zero divider, R9 saturation
    rate = 16'd0;
    v0 = vcnt;
    @(negedge clk) mode = 1'b1;
    repeat (1500) @(negedge clk);
    check(vcnt - v0 >= 20, "R8 zero divider runs back-to-back", vcnt - v0, 20);
    check(drop == 8'hFF, "R9 drop saturates", drop, 8'hFF);
    @(negedge clk) mode = 1'b0;
    repeat (80) @(negedge clk);
    check(drop == 8'hFF, "R9 drop holds at max", drop, 8'hFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule